// File: doc/BRIEF.md
# Sequential Booth Multiplier for Signed Operands

This block multiplies two signed two's-complement numbers of `W` bits each and returns their exact product of `2W` bits. It takes one clock cycle per multiplier bit. The block examines the lowest multiplier bit together with the bit that was shifted out on the previous step. From that pair it decides whether to add the multiplicand to a running partial sum, subtract it, or leave the sum alone. After that decision the whole {sum, multiplier, history} chain moves one place to the right, and the sign bit is copied in from the left. Because the shift keeps the sign, negative operands need no correction step at the end.

To use it, pulse `start` for one cycle while the block is idle, with both operands on the inputs. `busy` then stays high for exactly `W` cycles. After that `done` pulses for one cycle, and the result is already on `product`. The result stays there until the next operation completes. Inputs are sampled only in the start cycle, and a `start` that arrives while an operation is running is ignored.

Top module: `booth_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen while idle raises `busy` on the next clock edge. `busy` then stays high for exactly `W` cycles. `done` is high for the single cycle that follows, and is never high in two consecutive cycles.
- R3: At `done`, `product` holds the signed product of the two operands sampled at the start, as a 2W-bit two's-complement value.
- R4: The result is also correct when either operand or both operands are the most negative value, -2^(W-1). For example, with W=8, -128 x -128 = 16384 and -128 x 127 = -16256.
- R5: A `start` asserted while `busy` is high is ignored. The running operation finishes at its original time with its original result.
- R6: `product` changes only on the clock edge that raises `done`. At all other times it holds its value.
- R7: Changing `mcand` or `mplier` while `busy` is high does not change the result.
- R8: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product, registered |

## Verification
A wrong add/subtract choice, or a logical shift used in place of an arithmetic one, leaves no trace until the run ends. It then shows up at `done` as a wrong `product`, `W` cycles after the start. Operands with mixed signs and the most negative value are the inputs most likely to expose these faults. A miscounted iteration counter shows up sooner, as `busy` with the wrong length and `done` arriving at the wrong time. The checks on the busy length and the done timing catch this even when the product happens to come out right.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // Recode the current low multiplier bit and the previous one
  function automatic booth_op_e decode_pair(input logic cur, input logic prev);
    case ({cur, prev})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          sub,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] b_eff;

  // Subtract by adding the inverted operand plus one; the carry out is dropped
  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + AW'(sub);
  end
endmodule

// File: rtl/booth_counter.sv
module booth_counter #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(W);
    end else if (dec && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  // One guard bit keeps A - M exact when M is the most negative value
  localparam int AW = W + 1;

  logic [AW-1:0] acc, m_reg, sum, acc_op, acc_sh;
  logic [W-1:0]  q, q_sh;
  logic          qm1;
  booth_op_e     op;
  logic          load, last;

  assign load = start && !busy;

  always_comb op = decode_pair(q[0], qm1);

  booth_addsub #(.AW(AW)) u_addsub (
    .a   (acc),
    .b   (m_reg),
    .sub (op == OP_SUB),
    .sum (sum)
  );

  // Conditional update, then arithmetic right shift of {acc, q, qm1}
  always_comb begin
    acc_op = (op == OP_HOLD) ? acc : sum;
    acc_sh = {acc_op[AW-1], acc_op[AW-1:1]};
    q_sh   = {acc_op[0], q[W-1:1]};
  end

  booth_counter #(.W(W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .dec  (busy),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
      acc     <= '0;
      m_reg   <= '0;
      q       <= '0;
      qm1     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        acc   <= '0;
        m_reg <= {mcand[W-1], mcand};
        q     <= mplier;
        qm1   <= 1'b0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc <= acc_sh;
        q   <= q_sh;
        qm1 <= q[0];
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= {acc_sh[W-1:0], q_sh};
        end
      end
    end
  end
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0]  run_len;
  logic [W-1:0]   a_cap, b_cap;
  logic [2*W-1:0] ref_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      a_cap   <= '0;
      b_cap   <= '0;
    end else begin
      run_len <= busy ? run_len + LW'(1) : '0;
      if (start && !busy) begin
        a_cap <= mcand;
        b_cap <= mplier;
      end
    end
  end

  always_comb
    ref_prod = {{W{a_cap[W-1]}}, a_cap} * {{W{b_cap[W-1]}}, b_cap};

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == LW'(W) && done));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> product == ref_prod);

  p_product_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
endmodule

bind booth_mult booth_mult_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/booth_mult_test.sv
module booth_mult_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  booth_mult #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: plain, 1: extra start mid-run (R5), 2: scramble operands mid-run (R7)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int mode);
    int cycles = 0;
    logic [2*W-1:0] held;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 64'(busy), 64'd1);
    cycles = 1;
    while (!done) begin
      if (mode == 1 && cycles == 3) begin
        mcand = ~a; mplier = b + 8'd5; start = 1'b1;
      end else if (mode == 2) begin
        mcand = W'($urandom); mplier = W'($urandom);
      end
      @(negedge clk);
      start = 1'b0;
      if (!done) cycles++;
      if (cycles > 4 * W) begin
        chk("R2 watchdog", 64'(cycles), 64'(W));
        break;
      end
    end
    chk("R2 busy length", 64'(cycles), 64'(W));
    chk("R8 done without busy", 64'(busy), 64'd0);
    case (mode)
      1:       chk("R5 start ignored while busy", 64'(product), 64'(exp_prod(a, b)));
      2:       chk("R7 operands sampled at start", 64'(product), 64'(exp_prod(a, b)));
      default: chk("R3 product", 64'(product), 64'(exp_prod(a, b)));
    endcase
    held = product;
    @(negedge clk);
    chk("R2 done single pulse", 64'(done), 64'd0);
    mcand = W'($urandom); mplier = W'($urandom);
    @(negedge clk);
    chk("R6 product held", 64'(product), 64'(held));
  endtask

  initial begin
    #2000000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 product after reset", 64'(product), 64'd0);

    run_op(8'd7, 8'd3, 0);           // R3: 21
    chk("R3 7x3=21", 64'(product), 64'd21);
    run_op(8'hF9, 8'd3, 0);          // R3: -7 x 3
    run_op(8'd0, 8'h80, 0);
    run_op(8'h80, 8'h80, 0);         // R4: -128 x -128
    chk("R4 -128x-128", 64'(product), 64'd16384);
    run_op(8'h80, 8'h7F, 0);         // R4: -128 x 127
    chk("R4 -128x127", 64'(product), 64'(16'hC080));
    run_op(8'h7F, 8'h80, 0);         // R4
    run_op(8'hFF, 8'hFF, 0);
    run_op(8'h55, 8'hAA, 1);         // R5
    run_op(8'h80, 8'h81, 2);         // R7 with R4 operand

    for (int i = 0; i < 40; i++)
      run_op(W'($urandom), W'($urandom), i % 3);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule